// File: doc/BRIEF.md
# Clock Manager Reset Sequencer

This block brings one clock-generating delay-locked loop (DLL), or a cascade of two, out of reset in a fixed order. It then releases the logic that runs on the generated clock. All sequencing runs on the free-running input clock, because a DLL's output clock stops while that DLL is held in reset. A timer clocked from that output would therefore never expire.

After the external asynchronous reset is removed, the sequencer drives a minimum-width reset pulse into the first DLL and waits for that DLL to lock. In a cascade of two, it then pulses the second DLL's reset and waits for the second DLL to lock. Only then does it release the downstream reset, through a synchronizer on the generated clock. A lock that does not arrive within a bounded window restarts the whole sequence and raises a sticky flag. A lock lost while running also restarts the sequence, and the downstream logic is put back in reset at once. The chain depth parameter accepts 1 or 2, and any other value stops elaboration. The current sequencer state is available on a status port for observation.

Top module: `clk_rst_seq`

## Requirements
- R1: While `rst_ni` is low, `state_o` is 0, every bit of `dll_rst_o` is 1, `core_rst_no` is 0 and `timeout_o` is 0. The flag clears asynchronously.
- R2: Each bit of `dll_rst_o` stays high for at least `MIN_RST_CYC` consecutive `clk_i` cycles (default 4) before it falls. This holds for the first pulse and for every restart.
- R3: `state_o` codes are: 0 idle, 1 first DLL in reset, 2 waiting for first lock, 3 second DLL in reset, 4 waiting for second lock, 5 running. Each lock input passes through two flops, so a wait state is left on the third `clk_i` edge after the lock input rises. With default timing and two DLLs whose locks rise d0 and d1 cycles after their resets fall, state 5 is first seen d0+d1+15 cycles after reset release.
- R4: With two DLLs, `dll_rst_o[1]` falls only after the first DLL's lock has been seen, and never while `dll_rst_o[0]` is high.
- R5: `core_rst_no` is high only in state 5. It rises through two `gen_clk_i` flops and is still low in the first `clk_i` cycle of state 5.
- R6: If lock is not seen by the `LOCK_TIMEOUT`-th `clk_i` edge after a wait state is entered, the sequencer returns to state 1 and sets `timeout_o` on that same edge. A lock seen on that edge wins, so a lock rising up to `LOCK_TIMEOUT`-3 cycles after the reset falls succeeds.
- R7: `timeout_o` stays high until `rst_ni` is asserted, including after a later successful lock.
- R8: A lock input that falls in state 5 sends the sequencer to state 1 on the third `clk_i` edge after the drop. `core_rst_no` falls on that edge without waiting for `gen_clk_i`. The sequence then runs again to state 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running input clock; all sequencing runs here |
| rst_ni | input | 1 | Asynchronous active-low reset request |
| gen_clk_i | input | 1 | Generated clock of the last DLL, used only for downstream release |
| lock_i | input | NUM_DLL | Lock indication from each DLL, asynchronous |
| dll_rst_o | output | NUM_DLL | Active-high reset to each DLL |
| core_rst_no | output | 1 | Active-low downstream reset, released on `gen_clk_i` |
| timeout_o | output | 1 | Sticky lock-timeout flag |
| state_o | output | 3 | Current sequencer state code |

## Verification
The bench models each DLL as a lock that rises a programmed number of cycles after its reset falls. It sweeps these delays across the timeout boundary: a lock arriving on the last allowed edge must win, and one cycle later must time out. A design with an off-by-one timeout would either reject the boundary lock or accept the late one. A design that restarts only the failing DLL would show state 3 instead of 1 when the flag rises. Exact arrival cycles in state 5 expose a missing or extra synchronizer stage. Forced lock drops in the running state, and the restart pulse width after a timeout, expose a downstream reset released too early, a second DLL freed before the first locks, or a restart pulse that is too short.

// File: rtl/clk_rst_seq_pkg.sv
package clk_rst_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_RST_DLL0   = 3'd1,
    ST_WAIT_LOCK0 = 3'd2,
    ST_RST_DLL1   = 3'd3,
    ST_WAIT_LOCK1 = 3'd4,
    ST_RUN        = 3'd5
  } seq_state_e;
endpackage

// File: rtl/clk_rst_seq_lock_sync.sv
module clk_rst_seq_lock_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '0;
      else         pipe_q <= {pipe_q[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/clk_rst_seq_fsm.sv
module clk_rst_seq_fsm
  import clk_rst_seq_pkg::*;
#(
  parameter int NUM_DLL      = 2,
  parameter int MIN_RST_CYC  = 4,
  parameter int LOCK_TIMEOUT = 1024
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_DLL-1:0] lock_s_i,
  output logic [NUM_DLL-1:0] dll_rst_o,
  output logic               run_o,
  output logic               timeout_o,
  output seq_state_e         state_o
);
  localparam int CNT_MAX = (MIN_RST_CYC > LOCK_TIMEOUT) ? MIN_RST_CYC : LOCK_TIMEOUT;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(MIN_RST_CYC - 1);
  localparam logic [CNT_W-1:0] TO_LAST  = CNT_W'(LOCK_TIMEOUT - 1);
  localparam seq_state_e ST_AFTER0 = (NUM_DLL == 2) ? ST_RST_DLL1 : ST_RUN;

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             to_q, to_set, run_q;
  logic             lock0, lock_last, all_lock;

  assign lock0     = lock_s_i[0];
  assign lock_last = lock_s_i[NUM_DLL-1];
  assign all_lock  = &lock_s_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + 1'b1;
    to_set  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        state_d = ST_RST_DLL0;
        cnt_d   = '0;
      end
      ST_RST_DLL0: begin
        if (cnt_q == RST_LAST) begin
          state_d = ST_WAIT_LOCK0;
          cnt_d   = '0;
        end
      end
      ST_WAIT_LOCK0: begin
        if (lock0) begin
          state_d = ST_AFTER0;
          cnt_d   = '0;
        end else if (cnt_q == TO_LAST) begin
          state_d = ST_RST_DLL0;
          cnt_d   = '0;
          to_set  = 1'b1;
        end
      end
      ST_RST_DLL1: begin
        if (!lock0) begin
          state_d = ST_RST_DLL0;
          cnt_d   = '0;
        end else if (cnt_q == RST_LAST) begin
          state_d = ST_WAIT_LOCK1;
          cnt_d   = '0;
        end
      end
      ST_WAIT_LOCK1: begin
        if (!lock0) begin
          state_d = ST_RST_DLL0;
          cnt_d   = '0;
        end else if (lock_last) begin
          state_d = ST_RUN;
          cnt_d   = '0;
        end else if (cnt_q == TO_LAST) begin
          // restart the whole chain, not just the second DLL
          state_d = ST_RST_DLL0;
          cnt_d   = '0;
          to_set  = 1'b1;
        end
      end
      ST_RUN: begin
        cnt_d = '0;
        if (!all_lock) state_d = ST_RST_DLL0;
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      to_q    <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      to_q    <= to_q | to_set;
      run_q   <= (state_d == ST_RUN);
    end
  end

  for (genvar d = 0; d < NUM_DLL; d++) begin : g_dll_rst
    if (d == 0) begin : g_first
      assign dll_rst_o[d] = (state_q == ST_IDLE) || (state_q == ST_RST_DLL0);
    end else begin : g_second
      assign dll_rst_o[d] = (state_q != ST_WAIT_LOCK1) && (state_q != ST_RUN);
    end
  end

  assign run_o     = run_q;
  assign timeout_o = to_q;
  assign state_o   = state_q;
endmodule

// File: rtl/clk_rst_seq_release.sv
module clk_rst_seq_release #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] pipe_q;
  // assert asynchronously, release on clk_i
  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) pipe_q <= '0;
    else          pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end
  assign rst_no = pipe_q[STAGES-1];
endmodule

// File: rtl/clk_rst_seq.sv
module clk_rst_seq
  import clk_rst_seq_pkg::*;
#(
  parameter int NUM_DLL      = 2,
  parameter int MIN_RST_CYC  = 4,
  parameter int LOCK_TIMEOUT = 1024,
  parameter int SYNC_STAGES  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               gen_clk_i,
  input  logic [NUM_DLL-1:0] lock_i,
  output logic [NUM_DLL-1:0] dll_rst_o,
  output logic               core_rst_no,
  output logic               timeout_o,
  output logic [2:0]         state_o
);
  if (NUM_DLL < 1 || NUM_DLL > 2) begin : g_bad_depth
    $error("clk_rst_seq: NUM_DLL must be 1 or 2");
  end

  logic [NUM_DLL-1:0] lock_s;
  logic               run;
  logic               rel_arst_n;
  seq_state_e         state;

  clk_rst_seq_lock_sync #(
    .WIDTH (NUM_DLL),
    .STAGES(SYNC_STAGES)
  ) u_lock_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(lock_i),
    .sync_o (lock_s)
  );

  clk_rst_seq_fsm #(
    .NUM_DLL     (NUM_DLL),
    .MIN_RST_CYC (MIN_RST_CYC),
    .LOCK_TIMEOUT(LOCK_TIMEOUT)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lock_s_i (lock_s),
    .dll_rst_o(dll_rst_o),
    .run_o    (run),
    .timeout_o(timeout_o),
    .state_o  (state)
  );

  assign rel_arst_n = rst_ni & run;

  clk_rst_seq_release #(
    .STAGES(SYNC_STAGES)
  ) u_release (
    .clk_i  (gen_clk_i),
    .arst_ni(rel_arst_n),
    .rst_no (core_rst_no)
  );

  assign state_o = state;
endmodule

// File: rtl/clk_rst_seq_chk.sv
module clk_rst_seq_chk #(
  parameter int NUM_DLL     = 2,
  parameter int MIN_RST_CYC = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_DLL-1:0] dll_rst_o,
  input logic               core_rst_no,
  input logic               timeout_o,
  input logic [2:0]         state_o
);
  for (genvar d = 0; d < NUM_DLL; d++) begin : g_width
    logic [15:0] w_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           w_q <= '0;
      else if (!dll_rst_o[d]) w_q <= '0;
      else if (w_q != 16'hffff) w_q <= w_q + 16'd1;
    end
    AST_RST_MIN_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(dll_rst_o[d]) |-> (w_q >= 16'(MIN_RST_CYC))); // R2
  end

  if (NUM_DLL == 2) begin : g_order
    AST_DLL_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !dll_rst_o[1] |-> !dll_rst_o[0]); // R4
  end

  AST_CORE_ONLY_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_no |-> (state_o == 3'd5)); // R5

  AST_RUN_ALL_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd5) |-> (dll_rst_o == '0)); // R3

  AST_STATE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 3'd5); // R3

  AST_TIMEOUT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> (state_o == 3'd1)); // R6

  AST_TIMEOUT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> timeout_o); // R7

  AST_DROP_RESETS_CORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_o) == 3'd5 && state_o != 3'd5) |-> !core_rst_no); // R8
endmodule

bind clk_rst_seq clk_rst_seq_chk #(
  .NUM_DLL    (NUM_DLL),
  .MIN_RST_CYC(MIN_RST_CYC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dll_rst_o  (dll_rst_o),
  .core_rst_no(core_rst_no),
  .timeout_o  (timeout_o),
  .state_o    (state_o)
);

// File: tb/clk_rst_seq_tb_top.sv
module clk_rst_seq_tb_top;
  localparam int NUM_DLL = 2;
  localparam int MIN_RST = 4;
  localparam int TO      = 32;
  localparam int NVEC    = 6;
  // lock delay of DLL0, lock delay of DLL1, expected timeout flag
  localparam int VEC_D0[NVEC] = '{0, 5, 29, 30, 4, 2};
  localparam int VEC_D1[NVEC] = '{0, 12, 3, 2, 30, 29};
  localparam int VEC_TO[NVEC] = '{0, 0, 0, 1, 1, 0};

  logic clk = 1'b0, gen_clk = 1'b0, rst_n = 1'b0;
  logic [NUM_DLL-1:0] lock = '0;
  logic [NUM_DLL-1:0] force_low = '0;
  logic [NUM_DLL-1:0] dll_rst;
  logic core_rst_n, to_flag;
  logic [2:0] state;

  int checks = 0, fails = 0;
  int dly[NUM_DLL] = '{0, 0};
  int lcnt[NUM_DLL] = '{0, 0};
  int wcnt[NUM_DLL] = '{0, 0};
  int min_w[NUM_DLL] = '{1000, 1000};
  logic [NUM_DLL-1:0] prev_rst = '1;
  logic prev_core = 1'b0;
  int ord_err = 0, rel_err = 0;
  bit done = 0;

  always #2 clk = ~clk;      // 250 MHz
  always #3 gen_clk = ~gen_clk;

  clk_rst_seq #(
    .NUM_DLL     (NUM_DLL),
    .MIN_RST_CYC (MIN_RST),
    .LOCK_TIMEOUT(TO)
  ) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .gen_clk_i  (gen_clk),
    .lock_i     (lock),
    .dll_rst_o  (dll_rst),
    .core_rst_no(core_rst_n),
    .timeout_o  (to_flag),
    .state_o    (state)
  );

  // DLL lock model and monitors
  always @(negedge clk) begin
    for (int d = 0; d < NUM_DLL; d++) begin
      if (dll_rst[d]) wcnt[d]++;
      else begin
        if (prev_rst[d] && wcnt[d] < min_w[d]) min_w[d] = wcnt[d];
        wcnt[d] = 0;
      end
      if (dll_rst[d]) begin
        lcnt[d] <= 0;
        lock[d] <= 1'b0;
      end else if (force_low[d]) lock[d] <= 1'b0;
      else if (lcnt[d] >= dly[d]) lock[d] <= 1'b1;
      else lcnt[d] <= lcnt[d] + 1;
    end
    if (prev_rst[1] && !dll_rst[1] && !lock[0]) ord_err++;
    if (!prev_core && core_rst_n && state != 3'd5) rel_err++;
    prev_rst  = dll_rst;
    prev_core = core_rst_n;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_all();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic wait_core(input int limit);
    for (int i = 0; i < limit && !core_rst_n; i++) @(negedge clk);
  endtask

  task automatic run_vec(input int d0, input int d1, input int exp_to);
    int k, run_k;
    bit seen_to;
    @(negedge clk); #1;
    rst_n = 1'b0;
    force_low = '0;
    dly[0] = d0;
    dly[1] = d1;
    repeat (3) @(negedge clk);
    #1;
    min_w = '{1000, 1000};
    ord_err = 0;
    rel_err = 0;
    rst_n = 1'b1;
    k = 0;
    run_k = -1;
    seen_to = 0;
    while (k < 800 && !core_rst_n) begin
      @(negedge clk);
      k++;
      if (state == 3'd5 && run_k < 0) begin
        run_k = k;
        chk(core_rst_n == 1'b0, "R5 release not immediate", core_rst_n, 0);
      end
      if (to_flag && !seen_to) begin
        seen_to = 1;
        chk(state == 3'd1, "R6 restart from first DLL", state, 1);
        dly[0] = 2;
        dly[1] = 2;
      end
    end
    chk(core_rst_n == 1'b1, "R5 downstream released", core_rst_n, 1);
    chk(state == 3'd5, "R3 running state", state, 5);
    chk(to_flag == exp_to[0], "R6/R7 timeout flag", to_flag, exp_to);
    if (exp_to == 0) chk(run_k == d0 + d1 + 15, "R3 arrival cycle", run_k, d0 + d1 + 15);
    chk(min_w[0] >= MIN_RST, "R2 dll0 width", min_w[0], MIN_RST);
    chk(min_w[1] >= MIN_RST, "R2 dll1 width", min_w[1], MIN_RST);
    chk(ord_err == 0, "R4 order", ord_err, 0);
    chk(rel_err == 0, "R5 release only in run", rel_err, 0);
  endtask

  task automatic drop_test(input int d);
    @(negedge clk); #1;
    force_low[d] = 1'b1;
    repeat (3) @(negedge clk);
    chk(state == 3'd5 && core_rst_n, "R8 not before third edge", state, 5);
    @(negedge clk);
    chk(state == 3'd1, "R8 restart state", state, 1);
    chk(core_rst_n == 1'b0, "R8 core reset reasserted", core_rst_n, 0);
    #1;
    force_low[d] = 1'b0;
    wait_core(400);
    chk(core_rst_n == 1'b1 && state == 3'd5, "R8 relock", state, 5);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_all();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(state == 3'd0, "R1 state", state, 0);
    chk(dll_rst == 2'b11, "R1 dll resets", dll_rst, 3);
    chk(core_rst_n == 1'b0, "R1 core reset", core_rst_n, 0);
    chk(to_flag == 1'b0, "R1 timeout flag", to_flag, 0);

    for (int v = 0; v < NVEC; v++) begin
      run_vec(VEC_D0[v], VEC_D1[v], VEC_TO[v]);
      if (v == 3) begin
        // R7 flag held after success, cleared only by reset (R1)
        repeat (20) @(negedge clk);
        chk(to_flag == 1'b1, "R7 sticky while running", to_flag, 1);
        #1 rst_n = 1'b0;
        #1;
        chk(to_flag == 1'b0, "R1 async flag clear", to_flag, 0);
        chk(core_rst_n == 1'b0, "R1 async core reset", core_rst_n, 0);
      end
    end

    drop_test(1);
    drop_test(0);
    chk(to_flag == 1'b0, "R7 no spurious timeout", to_flag, 0);
    finish_all();
  end
endmodule